// File: doc/BRIEF.md
# Enquiry-Triggered Transmit Controller

This controller lets a remote host make a display terminal send part of its screen as if the operator had pressed the transmit key. The host embeds an enquiry control character in its message. The controller treats that character exactly like a local key press and latches a pending-send request. It then waits for the end-of-text character that closes the host's own message. At that point it shuts off receive steering, emits a one-cycle initialize pulse and loads a three-byte header into the outgoing buffer registers.

After the header is ready, the controller watches the circular screen-memory scan for an operator-placed end-of-text mark. The mark must lie on the cursor's row, at or right of the cursor column. When such a mark passes, a one-cycle transmit-start pulse gives the row and the first and last columns of the span to send. The controller then winds down in two steps. If a whole frame of memory passes with no usable mark, the request is dropped without a send. The exception is a cursor reposition (end-of-transmission or form feed) that is in effect; then the request is kept.

Character codes are 7-bit ASCII. Positions are a row and a column within a screen of `ROWS` by `COLS` cells. By default the screen is 24 rows of 80 columns, so a span can never exceed one 80-column line.

Top module: `enq_xmit_ctrl`

## Requirements
- R1: In the idle state, a high `xmit_key` or a received enquiry character (0x05 with `rx_valid`) sets `req_pending`, `step_busy` and `line_busy` on the next clock edge. Either source has the same effect.
- R2: While waiting for the end of the host message, received characters other than end-of-text (0x03) leave the controller waiting with no `init_pulse`.
- R3: The cycle after a received 0x03 ends the wait, `init_pulse` is high for exactly one cycle. `rx_disable` rises in that same cycle and stays high until the controller is idle again.
- R4: `hdr_load` is high in the same cycle as `init_pulse`. In that cycle `hdr_byte0` = 0x02, `hdr_byte1` = `dev_addr` and `hdr_byte2` = 0x03. In every other cycle all three bytes are zero.
- R5: `hdr_ready` rises the cycle after `hdr_load`. `xmit_start` only occurs while both `req_pending` and `hdr_ready` are high.
- R6: A qualifying mark is a `scan_valid` cycle with `scan_char` = 0x03, `scan_row` equal to `cur_row`, and `cur_col` <= `scan_col` < `COLS`. The cycle after a qualifying mark, `xmit_start` is high for one cycle. `xmit_row` then equals the cursor row, `xmit_first_col` the cursor column and `xmit_last_col` the mark column.
- R7: A scanned 0x03 before the cursor column or on another row, or any other scanned character, produces no `xmit_start`.
- R8: A `frame_pulse` during the scan, with no qualifying mark in that cycle and `repos_hold` low, clears `req_pending`, `hdr_ready`, `rx_disable`, `step_busy` and `line_busy` on the next edge, with no send. With `repos_hold` high the request survives and a later mark still starts a send. A qualifying mark in the same cycle as `frame_pulse` wins.
- R9: After `xmit_start`, `step_busy` stays high for one more cycle and then falls. `line_busy` falls one cycle after `step_busy`, and the controller is then idle.
- R10: A key press or enquiry character arriving outside the idle state is ignored. A received 0x03 while idle has no effect.
- R11: A synchronous active-high `rst` returns the controller to idle with every output low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 7 | Received decoded character |
| xmit_key | input | 1 | Local transmit key press |
| dev_addr | input | 7 | Device address byte placed in the header |
| scan_valid | input | 1 | Screen-memory scan character strobe |
| scan_char | input | 7 | Character read by the scan |
| scan_row | input | 5 | Row of the scanned cell |
| scan_col | input | 7 | Column of the scanned cell |
| frame_pulse | input | 1 | One full memory scan completed |
| cur_row | input | 5 | Cursor row |
| cur_col | input | 7 | Cursor column |
| repos_hold | input | 1 | End-of-transmission or form-feed reposition in effect |
| req_pending | output | 1 | Pending-send request latch |
| rx_disable | output | 1 | Receive steering disabled |
| init_pulse | output | 1 | One-cycle initialize-transmit pulse |
| hdr_load | output | 1 | Header load strobe |
| hdr_byte0 | output | 7 | First header byte (start-of-text) |
| hdr_byte1 | output | 7 | Second header byte (device address) |
| hdr_byte2 | output | 7 | Third header byte (end-of-text) |
| hdr_ready | output | 1 | Header has been loaded |
| xmit_start | output | 1 | One-cycle transmit start |
| xmit_row | output | 5 | Row of the span to send |
| xmit_first_col | output | 7 | First column of the span |
| xmit_last_col | output | 7 | Last column of the span (the mark) |
| step_busy | output | 1 | Step latch |
| line_busy | output | 1 | Advance-line latch |

## Verification
Some rules are checked on every cycle. `init_pulse` and `xmit_start` each last one cycle. A start never occurs without both the request and the header flag, and never with receive steering enabled. The span never runs backwards. A frame with no mark and no reposition drops the request. The step latch clears before the line latch. Other behaviour only the bench scenarios can show: the mark-qualification geometry (before the cursor, another row, a mark on the cursor cell, the last column), the exact header byte values, the equivalence of key and enquiry character, requests ignored outside idle, and a request that survives a frame under `repos_hold`.

// File: rtl/enq_xmit_pkg.sv
package enq_xmit_pkg;
    localparam int CHAR_W = 7;
    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t C_STX = 7'h02;
    localparam char_t C_ETX = 7'h03;
    localparam char_t C_ENQ = 7'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_END,
        ST_LOAD_HDR,
        ST_SCAN,
        ST_XMIT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/enq_char_match.sv
module enq_char_match
    import enq_xmit_pkg::*;
#(
    parameter char_t CODE = C_ETX
) (
    input  logic  valid,
    input  char_t ch,
    output logic  hit
);
    assign hit = valid && (ch == CODE);
endmodule

// File: rtl/enq_mark_finder.sv
module enq_mark_finder #(
    parameter int COLS  = 80,
    parameter int ROW_W = 5,
    parameter int COL_W = 7
) (
    input  logic             enable,
    input  logic             mark_seen,
    input  logic [ROW_W-1:0] scan_row,
    input  logic [COL_W-1:0] scan_col,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [COL_W-1:0] cur_col,
    output logic             hit
);
    localparam logic [COL_W:0] COL_LIMIT = (COL_W+1)'(COLS);

    logic same_row;
    logic at_or_after;
    logic in_line;

    always_comb begin
        same_row    = (scan_row == cur_row);
        at_or_after = (scan_col >= cur_col);
        in_line     = ({1'b0, scan_col} < COL_LIMIT);
        hit         = enable && mark_seen && same_row && at_or_after && in_line;
    end
endmodule

// File: rtl/enq_hdr_gen.sv
module enq_hdr_gen
    import enq_xmit_pkg::*;
(
    input  logic  load,
    input  char_t dev_addr,
    output char_t byte0,
    output char_t byte1,
    output char_t byte2
);
    always_comb begin
        byte0 = load ? C_STX    : '0;
        byte1 = load ? dev_addr : '0;
        byte2 = load ? C_ETX    : '0;
    end
endmodule

// File: rtl/enq_xmit_ctrl.sv
module enq_xmit_ctrl
    import enq_xmit_pkg::*;
#(
    parameter int ROWS = 24,
    parameter int COLS = 80,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [6:0]       rx_char,
    input  logic             xmit_key,
    input  logic [6:0]       dev_addr,
    input  logic             scan_valid,
    input  logic [6:0]       scan_char,
    input  logic [ROW_W-1:0] scan_row,
    input  logic [COL_W-1:0] scan_col,
    input  logic             frame_pulse,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [COL_W-1:0] cur_col,
    input  logic             repos_hold,
    output logic             req_pending,
    output logic             rx_disable,
    output logic             init_pulse,
    output logic             hdr_load,
    output logic [6:0]       hdr_byte0,
    output logic [6:0]       hdr_byte1,
    output logic [6:0]       hdr_byte2,
    output logic             hdr_ready,
    output logic             xmit_start,
    output logic [ROW_W-1:0] xmit_row,
    output logic [COL_W-1:0] xmit_first_col,
    output logic [COL_W-1:0] xmit_last_col,
    output logic             step_busy,
    output logic             line_busy
);
    typedef struct packed {
        state_e           st;
        logic             req;
        logic             rxdis;
        logic             hrdy;
        logic             step;
        logic             line;
        logic             wind_ph;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] first;
        logic [COL_W-1:0] last;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, default: '0};

    ctl_t ctl_d, ctl_q;

    logic rx_enq, rx_etx, scan_etx, mark_hit, scan_en;

    enq_char_match #(.CODE(C_ENQ)) u_rx_enq (
        .valid(rx_valid), .ch(rx_char), .hit(rx_enq)
    );
    enq_char_match #(.CODE(C_ETX)) u_rx_etx (
        .valid(rx_valid), .ch(rx_char), .hit(rx_etx)
    );
    enq_char_match #(.CODE(C_ETX)) u_scan_etx (
        .valid(scan_valid), .ch(scan_char), .hit(scan_etx)
    );

    assign scan_en = (ctl_q.st == ST_SCAN) && ctl_q.req && ctl_q.hrdy;

    enq_mark_finder #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_finder (
        .enable   (scan_en),
        .mark_seen(scan_etx),
        .scan_row (scan_row),
        .scan_col (scan_col),
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .hit      (mark_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (xmit_key || rx_enq) begin
                    ctl_d.st   = ST_WAIT_END;
                    ctl_d.req  = 1'b1;
                    ctl_d.step = 1'b1;
                    ctl_d.line = 1'b1;
                end
            end
            ST_WAIT_END: begin
                if (rx_etx) begin
                    ctl_d.st    = ST_LOAD_HDR;
                    ctl_d.rxdis = 1'b1;
                end
            end
            ST_LOAD_HDR: begin
                ctl_d.st   = ST_SCAN;
                ctl_d.hrdy = 1'b1;
            end
            ST_SCAN: begin
                if (mark_hit) begin
                    ctl_d.st    = ST_XMIT;
                    ctl_d.row   = cur_row;
                    ctl_d.first = cur_col;
                    ctl_d.last  = scan_col;
                end else if (frame_pulse && !repos_hold) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.req   = 1'b0;
                    ctl_d.hrdy  = 1'b0;
                    ctl_d.rxdis = 1'b0;
                    ctl_d.step  = 1'b0;
                    ctl_d.line  = 1'b0;
                end
            end
            ST_XMIT: begin
                ctl_d.st      = ST_DONE;
                ctl_d.req     = 1'b0;
                ctl_d.hrdy    = 1'b0;
                ctl_d.wind_ph = 1'b0;
            end
            ST_DONE: begin
                if (!ctl_q.wind_ph) begin
                    ctl_d.step    = 1'b0;
                    ctl_d.wind_ph = 1'b1;
                end else begin
                    ctl_d.line    = 1'b0;
                    ctl_d.rxdis   = 1'b0;
                    ctl_d.wind_ph = 1'b0;
                    ctl_d.st      = ST_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    assign req_pending    = ctl_q.req;
    assign rx_disable     = ctl_q.rxdis;
    assign hdr_ready      = ctl_q.hrdy;
    assign step_busy      = ctl_q.step;
    assign line_busy      = ctl_q.line;
    assign init_pulse     = (ctl_q.st == ST_LOAD_HDR);
    assign hdr_load       = init_pulse;
    assign xmit_start     = (ctl_q.st == ST_XMIT);
    assign xmit_row       = ctl_q.row;
    assign xmit_first_col = ctl_q.first;
    assign xmit_last_col  = ctl_q.last;

    enq_hdr_gen u_hdr (
        .load    (hdr_load),
        .dev_addr(dev_addr),
        .byte0   (hdr_byte0),
        .byte1   (hdr_byte1),
        .byte2   (hdr_byte2)
    );
endmodule

// File: rtl/enq_xmit_chk.sv
module enq_xmit_chk
    import enq_xmit_pkg::*;
#(
    parameter int COLS = 80,
    localparam int COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_pulse,
    input logic             repos_hold,
    input logic             scan_valid,
    input logic [6:0]       scan_char,
    input logic             req_pending,
    input logic             rx_disable,
    input logic             init_pulse,
    input logic             hdr_load,
    input logic             hdr_ready,
    input logic             xmit_start,
    input logic [COL_W-1:0] xmit_first_col,
    input logic [COL_W-1:0] xmit_last_col,
    input logic             step_busy,
    input logic             line_busy
);
    AST_REQ_SETS_LATCHES: assert property (@(posedge clk) disable iff (rst)
        $rose(req_pending) |-> (step_busy && line_busy)); // R1
    AST_INIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        init_pulse |-> req_pending); // R2
    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> !init_pulse); // R3
    AST_START_RX_OFF: assert property (@(posedge clk) disable iff (rst)
        xmit_start |-> rx_disable); // R3
    AST_HDR_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        hdr_load |=> hdr_ready); // R5
    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        xmit_start |-> (req_pending && hdr_ready)); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        xmit_start |=> !xmit_start); // R6
    AST_SPAN_FORWARD: assert property (@(posedge clk) disable iff (rst)
        xmit_start |-> (xmit_last_col >= xmit_first_col)); // R6
    AST_FRAME_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (req_pending && hdr_ready && !xmit_start && frame_pulse && !repos_hold
         && !(scan_valid && scan_char == C_ETX)) |=> !req_pending); // R8
    AST_STEP_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        step_busy |-> line_busy); // R9
    AST_LINE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        ($fell(step_busy) && line_busy) |=> !line_busy); // R9
endmodule

bind enq_xmit_ctrl enq_xmit_chk #(.COLS(COLS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_pulse   (frame_pulse),
    .repos_hold    (repos_hold),
    .scan_valid    (scan_valid),
    .scan_char     (scan_char),
    .req_pending   (req_pending),
    .rx_disable    (rx_disable),
    .init_pulse    (init_pulse),
    .hdr_load      (hdr_load),
    .hdr_ready     (hdr_ready),
    .xmit_start    (xmit_start),
    .xmit_first_col(xmit_first_col),
    .xmit_last_col (xmit_last_col),
    .step_busy     (step_busy),
    .line_busy     (line_busy)
);

// File: tb/sim_enq_xmit_ctrl.sv
`timescale 1ns/1ps
module sim_enq_xmit_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, xmit_key = 0, scan_valid = 0, frame_pulse = 0, repos_hold = 0;
    logic [6:0] rx_char = 0, scan_char = 0, dev_addr = 7'h2A;
    logic [4:0] scan_row = 0, cur_row = 0, xmit_row;
    logic [6:0] scan_col = 0, cur_col = 0, xmit_first_col, xmit_last_col;
    logic req_pending, rx_disable, init_pulse, hdr_load, hdr_ready, xmit_start;
    logic step_busy, line_busy;
    logic [6:0] hdr_byte0, hdr_byte1, hdr_byte2;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    enq_xmit_ctrl u0 (.*);

    typedef struct packed {
        logic [4:0] srow;
        logic [6:0] scol;
        logic [6:0] sch;
        logic [4:0] crow;
        logic [6:0] ccol;
        logic       hit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd3,  7'd10, 7'h03, 5'd3,  7'd5, 1'b1},
        '{5'd3,  7'd5,  7'h03, 5'd3,  7'd5, 1'b1},
        '{5'd3,  7'd4,  7'h03, 5'd3,  7'd5, 1'b0},
        '{5'd4,  7'd10, 7'h03, 5'd3,  7'd5, 1'b0},
        '{5'd3,  7'd10, 7'h41, 5'd3,  7'd5, 1'b0},
        '{5'd0,  7'd79, 7'h03, 5'd0,  7'd0, 1'b1},
        '{5'd23, 7'd79, 7'h02, 5'd23, 7'd0, 1'b0},
        '{5'd23, 7'd0,  7'h03, 5'd23, 7'd0, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic request(input bit use_enq);
        if (use_enq) begin rx_valid = 1; rx_char = 7'h05; end
        else xmit_key = 1;
        tick();
        rx_valid = 0; xmit_key = 0;
    endtask

    task automatic send_rx(input logic [6:0] c);
        rx_valid = 1; rx_char = c;
        tick();
        rx_valid = 0;
    endtask

    task automatic scan_one(input logic [4:0] r, input logic [6:0] c, input logic [6:0] ch);
        scan_valid = 1; scan_row = r; scan_col = c; scan_char = ch;
        tick();
        scan_valid = 0;
    endtask

    task automatic frame();
        frame_pulse = 1;
        tick();
        frame_pulse = 0;
    endtask

    // brings the controller from idle to the scan phase
    task automatic to_scan(input bit use_enq);
        request(use_enq);
        send_rx(7'h03);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        chk("R11 reset req_pending", req_pending, 0);
        chk("R11 reset busy", {step_busy, line_busy, rx_disable, hdr_ready}, 0);
        chk("R11 reset pulses", {init_pulse, hdr_load, xmit_start}, 0);

        for (int i = 0; i < 8; i++) begin
            cur_row = VECS[i].crow;
            cur_col = VECS[i].ccol;
            request(i[0]);
            chk("R1 req_pending set", req_pending, 1);
            chk("R1 latches set", {step_busy, line_busy}, 2'b11);
            send_rx(7'h41);
            chk("R2 still waiting", init_pulse, 0);
            send_rx(7'h03);
            chk("R3 init_pulse", init_pulse, 1);
            chk("R3 rx_disable", rx_disable, 1);
            chk("R4 hdr_load", hdr_load, 1);
            chk("R4 header bytes", {hdr_byte0, hdr_byte1, hdr_byte2}, {7'h02, 7'h2A, 7'h03});
            tick();
            chk("R5 hdr_ready", hdr_ready, 1);
            chk("R3 init one cycle", init_pulse, 0);
            chk("R4 bytes zero", {hdr_byte0, hdr_byte1, hdr_byte2}, 0);
            scan_one(VECS[i].srow, VECS[i].scol, VECS[i].sch);
            if (VECS[i].hit) begin
                chk("R6 xmit_start", xmit_start, 1);
                chk("R6 span", {xmit_row, xmit_first_col, xmit_last_col},
                    {VECS[i].crow, VECS[i].ccol, VECS[i].scol});
                repeat (3) tick();
                chk("R9 idle after send", {step_busy, line_busy, rx_disable}, 0);
            end else begin
                chk("R7 no xmit_start", xmit_start, 0);
                frame();
                chk("R8 cancelled", {req_pending, hdr_ready, rx_disable, step_busy, line_busy}, 0);
                chk("R7 no send on cancel", xmit_start, 0);
            end
        end

        // R9 wind-down timeline
        cur_row = 5'd2; cur_col = 7'd1;
        to_scan(0);
        scan_one(5'd2, 7'd9, 7'h03);
        chk("R9 start step/line", {xmit_start, step_busy, line_busy}, 3'b111);
        tick();
        chk("R9 step held", {xmit_start, step_busy, line_busy}, 3'b011);
        tick();
        chk("R9 step cleared first", {step_busy, line_busy}, 2'b01);
        tick();
        chk("R9 line cleared", {step_busy, line_busy}, 2'b00);

        // R8 repos_hold keeps the request
        to_scan(1);
        repos_hold = 1;
        frame();
        repos_hold = 0;
        chk("R8 held under reposition", {req_pending, hdr_ready}, 2'b11);
        scan_one(5'd2, 7'd1, 7'h03);
        chk("R8 send after held frame", xmit_start, 1);
        repeat (3) tick();

        // R8 mark and frame together: mark wins
        to_scan(0);
        frame_pulse = 1;
        scan_one(5'd2, 7'd40, 7'h03);
        frame_pulse = 0;
        chk("R8 mark beats frame", xmit_start, 1);
        repeat (3) tick();

        // R10 key/enquiry during scan ignored
        to_scan(0);
        request(0);
        request(1);
        frame();
        chk("R10 scan-time request ignored", req_pending, 0);
        // R10 end-of-text while idle ignored
        send_rx(7'h03);
        chk("R10 idle ETX ignored", {init_pulse, req_pending, rx_disable}, 0);

        // R11 reset in mid-operation
        request(1);
        rst = 1;
        tick();
        rst = 0;
        chk("R11 mid-op reset", {req_pending, step_busy, line_busy}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule